// File: doc/BRIEF.md
# Row-Major March Test Sequencer with Complement-Paired Column Order

This block drives a six-element March test into a synchronous SRAM whose array is arranged as rows (word lines) by columns. Each element is applied to every column of one row before the row counter moves on. A cell on the active row that is not being accessed still sees its bit lines precharged at every access to its neighbours. Row-major ordering therefore gives each such cell a long unbroken run of that stress. Within a row, columns are visited in pairs made of a value and its bitwise complement, so the column address toggles every bit on alternate steps. The data polarity follows the column's top bit, which makes every successive write, and every successive expected read, invert all data bits.

Software or a test controller pulses `start`. The engine then issues one memory operation on every cycle with no pauses. It compares each read one cycle after the request and records the first mismatch. When the last read has been compared, it drops `busy` and raises `done`. The memory model and any physical address scrambling sit outside the block.

The controller is a state machine with five states:
- IDLE: the wait state after reset.
- READ: issues a read.
- WRITE: issues a write.
- DRAIN: one cycle in which the final read is compared.
- DONE: holds the result.

Its transitions are:
- start accepted (IDLE or DONE to WRITE).
- read-then-write (READ to WRITE on the same cell).
- step (READ or WRITE to the first operation of the next cell).
- element change (to READ or WRITE of the next element).
- finish (READ to DRAIN after the last cell of the final element).
- drain end (DRAIN to DONE).

The column parameter must be at least 2.

Top module: `rowsweep_march`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `mem_req` are low.
- R2: The elements run in index order 0 to 5: 0 = write 0 ascending; 1 = read 0 then write 1 ascending; 2 = read 1 then write 0 ascending; 3 = read 0 then write 1 descending; 4 = read 1 then write 0 descending; 5 = read 0 ascending. In elements 1 to 4 the write goes to the same address in the cycle after the read.
- R3: An element finishes every column of a row before the row changes. Ascending elements visit rows 0 up to the maximum; descending elements visit rows from the maximum down to 0.
- R4: In a row, step index k maps to column p when k is even and to ~p when k is odd, where p = k>>1 with the top column bit clear. With 3 column bits the ascending order is 0,7,1,6,2,5,3,4, and descending elements reverse it. `mem_addr` = {row, column}.
- R5: The write data is the element's nominal value XOR the column's top bit, copied to every data bit. Within an element each write is the bitwise inverse of the previous write.
- R6: From the cycle after `start` is accepted, `mem_req` is high on every cycle for 10 × (number of cells) consecutive cycles.
- R7: Read data is taken in the cycle after the read request. It is compared against the expected value (nominal XOR column top bit), copied to every bit, and any difference raises `fail`.
- R8: `fail_row`, `fail_col` and `fail_elem` (the element index from R2) hold the first mismatch and are not changed by later mismatches until the next start.
- R9: `busy` is high from the cycle after start until the final read has been compared, 10 × cells + 1 cycles. Then `done` is high and stays high. Accepting `start` clears `done` and `fail`.
- R10: A `start` pulse while `busy` is high has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (accepted in IDLE or DONE) |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test complete, result valid |
| mem_req | output | 1 | Memory operation this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ROW_BITS+COL_BITS | {row, column} |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| fail | output | 1 | A mismatch was seen |
| fail_row | output | ROW_BITS | Row of first mismatch |
| fail_col | output | COL_BITS | Column of first mismatch |
| fail_elem | output | 3 | Element index of first mismatch |

## Verification
The hardest situation to reach from the ports is a cell that first fails after several elements have passed over it. Only then does the capture logic have to keep the first record while later mismatches keep arriving. The bench models a memory with a bit stuck low on chosen cells. On a cell with the top column bit set, the first failure lands in element 1. On a cell with it clear, the failure waits until element 2. With both faults present, the capture must keep the earlier one. The full operation log is also compared, step by step, against an order the bench computes independently for all six elements.

// File: rtl/rowsweep_pkg.sv
package rowsweep_pkg;

    typedef enum logic [2:0] {
        EL_INIT   = 3'd0,
        EL_UP_RW1 = 3'd1,
        EL_UP_RW0 = 3'd2,
        EL_DN_RW1 = 3'd3,
        EL_DN_RW0 = 3'd4,
        EL_FINAL  = 3'd5
    } elem_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DRAIN,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic has_rd;
        logic has_wr;
        logic down;
        logic rd_val;
        logic wr_val;
    } elem_cfg_t;

    function automatic elem_cfg_t cfg_of(input elem_e e);
        elem_cfg_t c;
        case (e)
            EL_INIT:   c = '{has_rd: 1'b0, has_wr: 1'b1, down: 1'b0, rd_val: 1'b0, wr_val: 1'b0};
            EL_UP_RW1: c = '{has_rd: 1'b1, has_wr: 1'b1, down: 1'b0, rd_val: 1'b0, wr_val: 1'b1};
            EL_UP_RW0: c = '{has_rd: 1'b1, has_wr: 1'b1, down: 1'b0, rd_val: 1'b1, wr_val: 1'b0};
            EL_DN_RW1: c = '{has_rd: 1'b1, has_wr: 1'b1, down: 1'b1, rd_val: 1'b0, wr_val: 1'b1};
            EL_DN_RW0: c = '{has_rd: 1'b1, has_wr: 1'b1, down: 1'b1, rd_val: 1'b1, wr_val: 1'b0};
            EL_FINAL:  c = '{has_rd: 1'b1, has_wr: 1'b0, down: 1'b0, rd_val: 1'b0, wr_val: 1'b0};
            default:   c = '{has_rd: 1'b0, has_wr: 1'b0, down: 1'b0, rd_val: 1'b0, wr_val: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rowsweep_col_map.sv
module rowsweep_col_map #(
    parameter int COL_BITS = 4
) (
    input  logic [COL_BITS-1:0] idx,
    output logic [COL_BITS-1:0] col,
    output logic                upper
);
    logic [COL_BITS-1:0] base;

    // pair value p (top bit clear) with its complement on odd steps
    assign base  = {1'b0, idx[COL_BITS-1:1]};
    assign col   = idx[0] ? ~base : base;
    assign upper = col[COL_BITS-1];

endmodule

// File: rtl/rowsweep_ctrl.sv
module rowsweep_ctrl
    import rowsweep_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                upper,
    output logic [ROW_BITS-1:0] row,
    output logic [COL_BITS-1:0] idx,
    output elem_e               elem,
    output logic                rd_issue,
    output logic                wr_issue,
    output logic                wbit,
    output logic                ebit,
    output logic                busy,
    output logic                done,
    output logic                clr
);
    localparam logic [ROW_BITS-1:0] ROW_MAX = '1;
    localparam logic [COL_BITS-1:0] IDX_MAX = '1;

    state_e              state, state_n;
    elem_e               elem_n;
    logic [ROW_BITS-1:0] row_n;
    logic [COL_BITS-1:0] idx_n;
    elem_cfg_t           cfg, cfg_nx;
    elem_e               elem_inc;
    logic                last_cell;
    logic                step;

    assign elem_inc  = elem_e'(elem + 3'd1);
    assign cfg       = cfg_of(elem);
    assign cfg_nx    = cfg_of(elem_inc);
    assign last_cell = cfg.down ? (row == '0 && idx == '0)
                                : (row == ROW_MAX && idx == IDX_MAX);
    assign step      = (state == ST_WRITE) || (state == ST_READ && !cfg.has_wr);
    assign clr       = start && (state == ST_IDLE || state == ST_DONE);

    // next-state logic
    always_comb begin
        state_n = state;
        elem_n  = elem;
        row_n   = row;
        idx_n   = idx;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_n = ST_WRITE;
                    elem_n  = EL_INIT;
                    row_n   = '0;
                    idx_n   = '0;
                end
            end
            ST_READ:  if (cfg.has_wr) state_n = ST_WRITE;
            ST_WRITE: state_n = ST_WRITE;
            ST_DRAIN: state_n = ST_DONE;
            default:  state_n = ST_IDLE;
        endcase
        if (step) begin
            if (last_cell) begin
                if (elem == EL_FINAL) begin
                    state_n = ST_DRAIN;
                end else begin
                    elem_n  = elem_inc;
                    row_n   = cfg_nx.down ? ROW_MAX : '0;
                    idx_n   = cfg_nx.down ? IDX_MAX : '0;
                    state_n = cfg_nx.has_rd ? ST_READ : ST_WRITE;
                end
            end else begin
                if (cfg.down) begin
                    if (idx == '0) begin
                        idx_n = IDX_MAX;
                        row_n = row - 1'b1;
                    end else begin
                        idx_n = idx - 1'b1;
                    end
                end else begin
                    if (idx == IDX_MAX) begin
                        idx_n = '0;
                        row_n = row + 1'b1;
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end
                state_n = cfg.has_rd ? ST_READ : ST_WRITE;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            elem  <= EL_INIT;
            row   <= '0;
            idx   <= '0;
        end else begin
            state <= state_n;
            elem  <= elem_n;
            row   <= row_n;
            idx   <= idx_n;
        end
    end

    // outputs
    always_comb begin
        rd_issue = (state == ST_READ);
        wr_issue = (state == ST_WRITE);
        busy     = (state == ST_READ) || (state == ST_WRITE) || (state == ST_DRAIN);
        done     = (state == ST_DONE);
        wbit     = cfg.wr_val ^ upper;
        ebit     = cfg.rd_val ^ upper;
    end

    // assertion support: previous write inside the run
    logic  have_wr, last_wbit;
    elem_e last_welem;
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have_wr    <= 1'b0;
            last_wbit  <= 1'b0;
            last_welem <= EL_INIT;
        end else if (wr_issue) begin
            have_wr    <= 1'b1;
            last_wbit  <= wbit;
            last_welem <= elem;
        end
    end

    AST_WR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && have_wr && last_welem == elem) |-> (wbit != last_wbit)); // R5

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && cfg.has_wr) |=> (wr_issue && $stable(row) && $stable(idx))); // R2

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_issue || wr_issue) && $past(rd_issue || wr_issue) && $past(elem) == elem
         && row != $past(row))
        |-> ($past(idx) == (cfg.down ? {COL_BITS{1'b0}} : IDX_MAX))); // R3

    AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_issue || wr_issue) && start)
        |=> !(wr_issue && elem == EL_INIT && row == '0 && idx == '0)); // R10

endmodule

// File: rtl/rowsweep_resp_check.sv
module rowsweep_resp_check
    import rowsweep_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                rd_issue,
    input  logic                ebit,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  elem_e               elem,
    input  logic [DATA_W-1:0]   rdata,
    output logic                fail,
    output logic [ROW_BITS-1:0] fail_row,
    output logic [COL_BITS-1:0] fail_col,
    output logic [2:0]          fail_elem
);
    logic                pend;
    logic                p_exp;
    logic [ROW_BITS-1:0] p_row;
    logic [COL_BITS-1:0] p_col;
    logic [2:0]          p_elem;
    logic                mismatch;

    assign mismatch = pend && (rdata != {DATA_W{p_exp}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            p_exp     <= 1'b0;
            p_row     <= '0;
            p_col     <= '0;
            p_elem    <= '0;
            fail      <= 1'b0;
            fail_row  <= '0;
            fail_col  <= '0;
            fail_elem <= '0;
        end else begin
            pend <= rd_issue;
            if (rd_issue) begin
                p_exp  <= ebit;
                p_row  <= row;
                p_col  <= col;
                p_elem <= elem;
            end
            if (clr) begin
                fail      <= 1'b0;
                fail_row  <= '0;
                fail_col  <= '0;
                fail_elem <= '0;
            end else if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_row  <= p_row;
                fail_col  <= p_col;
                fail_elem <= p_elem;
            end
        end
    end

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> (fail && $stable(fail_row) && $stable(fail_col)
                            && $stable(fail_elem))); // R8

endmodule

// File: rtl/rowsweep_march.sv
module rowsweep_march
    import rowsweep_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 32,
    localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                fail,
    output logic [ROW_BITS-1:0] fail_row,
    output logic [COL_BITS-1:0] fail_col,
    output logic [2:0]          fail_elem
);
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] idx, col;
    elem_e               elem;
    logic                upper, rd_issue, wr_issue, wbit, ebit, clr;

    rowsweep_col_map #(.COL_BITS(COL_BITS)) u_map (
        .idx   (idx),
        .col   (col),
        .upper (upper)
    );

    rowsweep_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .upper    (upper),
        .row      (row),
        .idx      (idx),
        .elem     (elem),
        .rd_issue (rd_issue),
        .wr_issue (wr_issue),
        .wbit     (wbit),
        .ebit     (ebit),
        .busy     (busy),
        .done     (done),
        .clr      (clr)
    );

    rowsweep_resp_check #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rd_issue  (rd_issue),
        .ebit      (ebit),
        .row       (row),
        .col       (col),
        .elem      (elem),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_row  (fail_row),
        .fail_col  (fail_col),
        .fail_elem (fail_elem)
    );

    assign mem_req   = rd_issue | wr_issue;
    assign mem_we    = wr_issue;
    assign mem_addr  = {row, col};
    assign mem_wdata = {DATA_W{wbit}};

    AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done)); // R6

endmodule

// File: tb/test_rowsweep_march.sv
`timescale 1ns/1ps
module test_rowsweep_march;
    localparam int RB = 3, CB = 3, DW = 8;
    localparam int NCELL = 64, NOPS = 10 * NCELL;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic          busy, done, mem_req, mem_we, fail;
    logic [RB+CB-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [RB-1:0] fail_row;
    logic [CB-1:0] fail_col;
    logic [2:0]    fail_elem;

    always #2 clk = ~clk;

    rowsweep_march #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) i_rowsweep_march (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fail(fail),
        .fail_row(fail_row), .fail_col(fail_col), .fail_elem(fail_elem));

    // memory model with optional stuck-low bit 0 on two cells
    logic [DW-1:0] mem [0:NCELL-1];
    logic f_a = 1'b0, f_b = 1'b0;
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we)
                mem[mem_addr] <= ((f_a && mem_addr == 6'd21) || (f_b && mem_addr == 6'd10))
                                 ? (mem_wdata & 8'hFE) : mem_wdata;
            else
                mem_rdata <= mem[mem_addr];
        end
    end

    // operation log
    logic          lg_we [0:1023];
    logic [5:0]    lg_addr [0:1023];
    logic [7:0]    lg_wd [0:1023];
    int op_n = 0, busy_n = 0, cyc = 0, first_t = 0, last_t = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (op_n < 1024) begin
                lg_we[op_n]   <= mem_we;
                lg_addr[op_n] <= mem_addr;
                lg_wd[op_n]   <= mem_wdata;
            end
            if (op_n == 0) first_t <= cyc;
            last_t <= cyc;
            op_n <= op_n + 1;
        end
        if (busy) busy_n <= busy_n + 1;
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int k);
        int p = k >> 1;
        return (k & 1) ? (7 - p) : p;
    endfunction

    task automatic run(input int poke_at);
        int guard = 0;
        op_n = 0; busy_n = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !done && !fail, "R9", "start clears done/fail, busy set",
              {busy, done, fail}, 3'b100);
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (guard == poke_at) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(!busy && !done && !fail && !mem_req, "R1", "reset outputs",
              {busy, done, fail, mem_req}, 0);
    endtask

    task automatic t_clean;
        int hr [6] = '{0, 1, 1, 1, 1, 1};
        int hw [6] = '{1, 1, 1, 1, 1, 0};
        int dn [6] = '{0, 0, 0, 1, 1, 0};
        int rv [6] = '{0, 0, 1, 0, 1, 0};
        int wv [6] = '{0, 1, 0, 1, 0, 0};
        int n = 0;
        f_a = 0; f_b = 0;
        run(0);
        check(op_n == NOPS, "R6", "operation count", op_n, NOPS);
        check(last_t - first_t == NOPS - 1, "R6", "no idle cycles", last_t - first_t, NOPS - 1);
        check(busy_n == NOPS + 1, "R9", "busy cycles", busy_n, NOPS + 1);
        check(done && !busy, "R9", "done after run", done, 1);
        check(!fail, "R7", "clean memory no fail", fail, 0);
        for (int e = 0; e < 6; e++) begin
            int errs = 0, wflip_err = 0;
            int prev_wd = -1;
            for (int i = 0; i < NCELL; i++) begin
                int j = dn[e] ? (NCELL - 1 - i) : i;
                int r = j / 8, c = exp_col(j % 8);
                int pol = (c >> 2) & 1;
                int a = r * 8 + c;
                if (hr[e] != 0) begin
                    if (lg_we[n] !== 1'b0 || lg_addr[n] != a) errs++;
                    n++;
                end
                if (hw[e] != 0) begin
                    int d = ((wv[e] ^ pol) != 0) ? 255 : 0;
                    if (lg_we[n] !== 1'b1 || lg_addr[n] != a || lg_wd[n] != d) errs++;
                    if (prev_wd >= 0 && int'(lg_wd[n]) != (prev_wd ^ 255)) wflip_err++;
                    prev_wd = int'(lg_wd[n]);
                    n++;
                end
                if (rv[e] > 1) errs++;
            end
            check(errs == 0, "R2 R3 R4", $sformatf("element %0d op order", e), errs, 0);
            if (hw[e] != 0)
                check(wflip_err == 0, "R5", $sformatf("element %0d write inversion", e), wflip_err, 0);
        end
        for (int k = 0; k < 8; k++)
            check(lg_addr[k] == exp_col(k), "R4", $sformatf("row 0 step %0d column", k),
                  lg_addr[k], exp_col(k));
        check((lg_addr[0] ^ lg_addr[1]) == 6'd7, "R4", "pair toggles all column bits",
              lg_addr[0] ^ lg_addr[1], 7);
        check(lg_we[320] == 0 && lg_addr[320] == 60, "R3", "descending starts at top row",
              lg_addr[320], 60);
        check(lg_we[321] == 1 && lg_addr[321] == 60 && lg_wd[321] == 8'h00, "R2",
              "write follows read same cell", lg_wd[321], 0);
        repeat (5) @(negedge clk);
        check(done && !busy, "R9", "done held", done, 1);
    endtask

    task automatic t_fault(input bit a, input bit b, input int er, input int ec, input int ee);
        f_a = a; f_b = b;
        run(0);
        check(fail, "R7", "fault detected", fail, 1);
        check(fail_elem == ee, "R8", "first fail element", fail_elem, ee);
        check(fail_row == er, "R8", "first fail row", fail_row, er);
        check(fail_col == ec, "R8", "first fail column", fail_col, ec);
        f_a = 0; f_b = 0;
    endtask

    task automatic t_start_busy;
        run(100);
        check(op_n == NOPS, "R10", "start while busy: op count", op_n, NOPS);
        check(busy_n == NOPS + 1, "R10", "start while busy: busy cycles", busy_n, NOPS + 1);
        check(!fail, "R10", "start while busy: no fail", fail, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_fault(1, 0, 2, 5, 1);
        t_fault(0, 1, 1, 2, 2);
        t_fault(1, 1, 2, 5, 1);
        f_a = 0; f_b = 0;
        run(0);
        check(!fail && done, "R9", "restart after failing run clears fail", fail, 0);
        t_start_busy();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule